// File: doc/BRIEF.md
# Power-Mode Aware ADC Conversion Sequencer

This block is the digital sequencer that runs a successive-approximation converter through its phases (idle, sample, convert, commit) and decides what happens to a conversion when the host enters a low-power state or is reset. A small configuration register holds the module-enable bit, the clock-source choice (system clock or dedicated RC clock), the stop-in-idle choice, the interrupt enable and a 3-bit trigger select. These are loaded together through a write strobe.

In Sleep, the system clock stops, so a conversion survives only when the RC clock is selected. In Idle, the stop-in-idle bit decides whether the sequencer keeps going or halts. A halted conversion is dropped and is never resumed. When a conversion finishes during Sleep with the interrupt disabled, the converter powers itself down while the stored enable bit stays set. A completed conversion raises a one-cycle result-write strobe carrying the sampled code and the buffer slot. With the interrupt enabled, it also raises a one-cycle interrupt that doubles as the wake request.

The analog converter is modelled by a fixed latency: the input code is captured at the end of sampling and committed after the convert phase.

Top module: `adc_pm_seq`

## Requirements
- R1: After reset, `converting`, `bufWrite`, `wakeIrq`, `modPowered`, `cfgOn` and `wrIdx` are all 0.
- R2: With trigger select not equal to 3'b111, a `startReq` seen while idle and powered raises `converting` for SAMPLE_CLKS+CONV_CLKS (2+14) cycles. This is followed by a one-cycle `bufWrite` with `wrData` equal to the `anaIn` value held during sampling. `wrIdx` points at the slot being written and then advances by one, wrapping at BUF_DEPTH (16).
- R3: `wakeIrq` pulses for exactly the `bufWrite` cycle when the stored interrupt enable is 1, and stays 0 when it is 0.
- R4: Trigger select 3'b111 starts conversions with no `startReq`. The first one commits 17 cycles after the configuration write, and the following ones commit every 18 cycles.
- R5: Entering Sleep with the system clock selected (RC select 0) aborts a running conversion. `converting` is 0 one cycle later, no `bufWrite` or `wakeIrq` follows, and nothing resumes after Sleep ends.
- R6: With RC select 1, a conversion keeps running through Sleep and commits with normal timing.
- R7: A conversion that completes in Sleep with the interrupt disabled leaves `modPowered` at 0 while `cfgOn` stays 1. Later starts are ignored until the enable is written again.
- R8: In Idle, stop-in-idle 0 lets a conversion complete normally, while stop-in-idle 1 aborts it exactly as in R5.
- R9: The configuration survives Sleep: after Sleep ends, a start works with the earlier settings and no rewrite.
- R10: Reset in the middle of a conversion aborts it, clears the configuration and returns all outputs to the R1 values.
- R11: `startReq` is ignored while the module is unpowered and while a conversion is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| cfgWe | input | 1 | Load all configuration fields |
| cfgOnIn | input | 1 | Module enable to load |
| cfgRcSelIn | input | 1 | Clock source to load: 1 = dedicated RC clock |
| cfgStopIdleIn | input | 1 | Stop-in-idle to load |
| cfgIrqEnIn | input | 1 | Interrupt enable to load |
| cfgTrigIn | input | 3 | Trigger select to load; 3'b111 = automatic |
| startReq | input | 1 | Software start request (manual triggers) |
| sleepIn | input | 1 | Host is in Sleep |
| idleIn | input | 1 | Host is in Idle |
| anaIn | input | RES_W | Code the converter model returns |
| converting | output | 1 | Sample or convert phase active |
| bufWrite | output | 1 | One-cycle result-buffer write strobe |
| wakeIrq | output | 1 | One-cycle interrupt / wake request |
| modPowered | output | 1 | Converter powered |
| cfgOn | output | 1 | Stored module-enable bit |
| wrIdx | output | IDX_W | Result-buffer slot for the write |
| wrData | output | RES_W | Result code for the write |

## Verification
The assertions take for granted that the configuration is not written while the host sleeps, because a sleeping processor issues no writes. They also assume `anaIn` is steady during sampling. The stimulus drives `cfgWe` only with `sleepIn` and `idleIn` low, and changes `anaIn` only between conversions. Sleep and Idle are never raised together, so each abort case isolates one halt rule. Random runs vary the code, interrupt enable, manual trigger code and gap length, while directed cases place low-power entry and reset inside a running conversion.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2,
    ST_DONE    = 2'd3
  } seqState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic capture;
    logic commit;
  } dpStrobe_t;

  localparam logic [2:0] TRIG_AUTO = 3'b111;

endpackage

// File: rtl/adc_pm_cfg.sv
module adc_pm_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWe,
  input  logic       cfgOnIn,
  input  logic       cfgRcSelIn,
  input  logic       cfgStopIdleIn,
  input  logic       cfgIrqEnIn,
  input  logic [2:0] cfgTrigIn,
  input  logic       sleepIn,
  output logic       onBit,
  output logic       rcSel,
  output logic       stopIdle,
  output logic       irqEn,
  output logic [2:0] trigSel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onBit    <= 1'b0;
      rcSel    <= 1'b0;
      stopIdle <= 1'b0;
      irqEn    <= 1'b0;
      trigSel  <= 3'b000;
    end else if (cfgWe) begin
      onBit    <= cfgOnIn;
      rcSel    <= cfgRcSelIn;
      stopIdle <= cfgStopIdleIn;
      irqEn    <= cfgIrqEnIn;
      trigSel  <= cfgTrigIn;
    end
  end

  // configuration does not move across a sleep period
  AST_CFG_KEPT_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleepIn && !cfgWe) |=> ($stable(onBit) && $stable(rcSel) && $stable(irqEn) && $stable(trigSel))); // R9

endmodule

// File: rtl/adc_pm_dp.sv
module adc_pm_dp
  import adc_pm_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int BUF_DEPTH = 16,
  parameter int CNT_W     = 4,
  localparam int IDX_W    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [RES_W-1:0] anaIn,
  output logic [CNT_W-1:0] phaseCnt,
  output logic [RES_W-1:0] wrData,
  output logic [IDX_W-1:0] wrIdx
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUF_DEPTH - 1);

  logic [RES_W-1:0] sampleReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (strobe.cntClr) begin
      phaseCnt <= '0;
    end else if (strobe.cntInc) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // result holding register: deliberately left without reset
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      sampleReg <= anaIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdx <= '0;
    end else if (strobe.commit) begin
      wrIdx <= (wrIdx == IDX_LAST) ? '0 : wrIdx + 1'b1;
    end
  end

  assign wrData = sampleReg;

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> (wrIdx == (($past(wrIdx) == IDX_LAST) ? '0 : $past(wrIdx) + 1'b1))); // R2

endmodule

// File: rtl/adc_pm_ctrl.sv
module adc_pm_ctrl
  import adc_pm_pkg::*;
#(
  parameter int SAMPLE_CLKS = 2,
  parameter int CONV_CLKS   = 14,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic             cfgOnIn,
  input  logic             rcSel,
  input  logic             stopIdle,
  input  logic             irqEn,
  input  logic [2:0]       trigSel,
  input  logic             startReq,
  input  logic             sleepIn,
  input  logic             idleIn,
  input  logic [CNT_W-1:0] phaseCnt,
  output dpStrobe_t        strobe,
  output logic             converting,
  output logic             bufWrite,
  output logic             wakeIrq,
  output logic             modPowered
);

  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CLKS - 1);
  localparam logic [CNT_W-1:0] CONV_LAST   = CNT_W'(CONV_CLKS - 1);

  seqState_e state, stateNext;
  logic      halt;
  logic      run;
  logic      trigger;
  logic      powerDown;

  // sleep stops the system clock; idle halts only when asked to
  always_comb begin
    if (sleepIn) halt = !rcSel;
    else         halt = idleIn && stopIdle;
  end

  assign run     = modPowered && !halt;
  assign trigger = (trigSel == TRIG_AUTO) ? 1'b1 : startReq;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (run && trigger) begin
          stateNext     = ST_SAMPLE;
          strobe.cntClr = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (!run) begin
          stateNext = ST_IDLE;
        end else if (phaseCnt == SAMPLE_LAST) begin
          stateNext      = ST_CONVERT;
          strobe.capture = 1'b1;
          strobe.cntClr  = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_CONVERT: begin
        if (!run) begin
          stateNext = ST_IDLE;
        end else if (phaseCnt == CONV_LAST) begin
          stateNext = ST_DONE;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_DONE: begin
        stateNext     = ST_IDLE;
        strobe.commit = run;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // completion in sleep without an interrupt switches the converter off
  assign powerDown = strobe.commit && sleepIn && !irqEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         modPowered <= 1'b0;
    else if (cfgWe)     modPowered <= cfgOnIn;
    else if (powerDown) modPowered <= 1'b0;
  end

  assign converting = (state == ST_SAMPLE) || (state == ST_CONVERT);
  assign bufWrite   = strobe.commit;
  assign wakeIrq    = strobe.commit && irqEn;

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrite |=> !bufWrite); // R2
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wakeIrq |=> !wakeIrq); // R3
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && !run) |=> (state == ST_IDLE)); // R5
  AST_HALTED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && halt) |=> !converting); // R8
  AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !modPowered |=> !converting); // R11
  AST_POWER_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(modPowered) && !$past(cfgWe)) |-> $past(bufWrite && sleepIn)); // R7

endmodule

// File: rtl/adc_pm_seq.sv
module adc_pm_seq
  import adc_pm_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int BUF_DEPTH   = 16,
  parameter int SAMPLE_CLKS = 2,
  parameter int CONV_CLKS   = 14,
  localparam int IDX_W      = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic             cfgOnIn,
  input  logic             cfgRcSelIn,
  input  logic             cfgStopIdleIn,
  input  logic             cfgIrqEnIn,
  input  logic [2:0]       cfgTrigIn,
  input  logic             startReq,
  input  logic             sleepIn,
  input  logic             idleIn,
  input  logic [RES_W-1:0] anaIn,
  output logic             converting,
  output logic             bufWrite,
  output logic             wakeIrq,
  output logic             modPowered,
  output logic             cfgOn,
  output logic [IDX_W-1:0] wrIdx,
  output logic [RES_W-1:0] wrData
);

  localparam int PHASE_MAX = (SAMPLE_CLKS > CONV_CLKS) ? SAMPLE_CLKS : CONV_CLKS;
  localparam int CNT_W     = $clog2(PHASE_MAX + 1);

  logic             rcSel;
  logic             stopIdle;
  logic             irqEn;
  logic [2:0]       trigSel;
  logic [CNT_W-1:0] phaseCnt;
  dpStrobe_t        strobe;

  adc_pm_cfg u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfgWe         (cfgWe),
    .cfgOnIn       (cfgOnIn),
    .cfgRcSelIn    (cfgRcSelIn),
    .cfgStopIdleIn (cfgStopIdleIn),
    .cfgIrqEnIn    (cfgIrqEnIn),
    .cfgTrigIn     (cfgTrigIn),
    .sleepIn       (sleepIn),
    .onBit         (cfgOn),
    .rcSel         (rcSel),
    .stopIdle      (stopIdle),
    .irqEn         (irqEn),
    .trigSel       (trigSel)
  );

  adc_pm_ctrl #(
    .SAMPLE_CLKS (SAMPLE_CLKS),
    .CONV_CLKS   (CONV_CLKS),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWe      (cfgWe),
    .cfgOnIn    (cfgOnIn),
    .rcSel      (rcSel),
    .stopIdle   (stopIdle),
    .irqEn      (irqEn),
    .trigSel    (trigSel),
    .startReq   (startReq),
    .sleepIn    (sleepIn),
    .idleIn     (idleIn),
    .phaseCnt   (phaseCnt),
    .strobe     (strobe),
    .converting (converting),
    .bufWrite   (bufWrite),
    .wakeIrq    (wakeIrq),
    .modPowered (modPowered)
  );

  adc_pm_dp #(
    .RES_W     (RES_W),
    .BUF_DEPTH (BUF_DEPTH),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .anaIn    (anaIn),
    .phaseCnt (phaseCnt),
    .wrData   (wrData),
    .wrIdx    (wrIdx)
  );

endmodule

// File: tb/adc_pm_seq_bench.sv
`timescale 1ns/1ps
module adc_pm_seq_bench;

  localparam int RES_W   = 10;
  localparam int DEPTH   = 16;
  localparam int LAT     = 16;   // sample + convert cycles
  localparam int AUTO_PD = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWe = 1'b0, cfgOnIn = 1'b0, cfgRcSelIn = 1'b0, cfgStopIdleIn = 1'b0, cfgIrqEnIn = 1'b0;
  logic [2:0] cfgTrigIn = 3'b000;
  logic startReq = 1'b0, sleepIn = 1'b0, idleIn = 1'b0;
  logic [RES_W-1:0] anaIn = '0;
  logic converting, bufWrite, wakeIrq, modPowered, cfgOn;
  logic [3:0] wrIdx;
  logic [RES_W-1:0] wrData;

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;
  int bIdx = 0;
  int seen = 0;
  logic sawIrq;

  always #2.5 clk = ~clk;

  adc_pm_seq u_adc_pm_seq (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgOnIn(cfgOnIn), .cfgRcSelIn(cfgRcSelIn),
    .cfgStopIdleIn(cfgStopIdleIn), .cfgIrqEnIn(cfgIrqEnIn), .cfgTrigIn(cfgTrigIn),
    .startReq(startReq), .sleepIn(sleepIn), .idleIn(idleIn), .anaIn(anaIn),
    .converting(converting), .bufWrite(bufWrite), .wakeIrq(wakeIrq), .modPowered(modPowered),
    .cfgOn(cfgOn), .wrIdx(wrIdx), .wrData(wrData)
  );

  function automatic int nextIdx(input int i);
    return (i + 1) % DEPTH;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfgWrite(input logic on, input logic rc, input logic stp, input logic irq, input logic [2:0] trg);
    cfgWe = 1'b1; cfgOnIn = on; cfgRcSelIn = rc; cfgStopIdleIn = stp; cfgIrqEnIn = irq; cfgTrigIn = trg;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic pulseStart(input logic [RES_W-1:0] code);
    anaIn = code; startReq = 1'b1;
    tick();
    startReq = 1'b0;
  endtask

  // ticks until bufWrite shows; checks slot and data there
  task automatic waitWrite(input string req, input logic [RES_W-1:0] code, output int n);
    n = 0;
    sawIrq = 1'b0;
    do begin
      tick();
      n++;
    end while (!bufWrite && n < 40);
    if (bufWrite) begin
      sawIrq = wakeIrq;
      check({req, " wrIdx"}, int'(wrIdx), bIdx);
      check({req, " wrData"}, int'(wrData), int'(code));
      bIdx = nextIdx(bIdx);
    end
  endtask

  task automatic quietFor(input string req, input int n);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (bufWrite || wakeIrq || converting) seen++;
    end
    check(req, seen, 0);
  endtask

  int n;

  initial begin
    void'($urandom(32'h5EED));
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 converting", int'(converting), 0);
    check("R1 bufWrite", int'(bufWrite), 0);
    check("R1 wakeIrq", int'(wakeIrq), 0);
    check("R1 modPowered", int'(modPowered), 0);
    check("R1 cfgOn", int'(cfgOn), 0);
    check("R1 wrIdx", int'(wrIdx), 0);

    // R2 / R3 manual conversion with interrupt
    cfgWrite(1, 0, 0, 1, 3'b000);
    check("R2 powered", int'(modPowered), 1);
    pulseStart(10'h155);
    check("R2 converting", int'(converting), 1);
    waitWrite("R2", 10'h155, n);
    check("R2 latency", n, LAT);
    check("R3 irq on", int'(sawIrq), 1);
    tick();
    check("R2 write single", int'(bufWrite), 0);
    check("R3 irq single", int'(wakeIrq), 0);

    // R3 interrupt disabled
    cfgWrite(1, 0, 0, 0, 3'b010);
    pulseStart(10'h2AA);
    waitWrite("R3", 10'h2AA, n);
    check("R3 irq off", int'(sawIrq), 0);
    tick();

    // R11 unpowered start and start while busy
    cfgWrite(0, 0, 0, 1, 3'b000);
    pulseStart(10'h011);
    check("R11 unpowered start", int'(converting), 0);
    cfgWrite(1, 0, 0, 1, 3'b000);
    pulseStart(10'h033);
    tick(); tick();
    startReq = 1'b1; tick(); startReq = 1'b0;
    waitWrite("R11", 10'h033, n);
    check("R11 busy start ignored", n, LAT - 3);
    tick();
    quietFor("R11 no second run", 5);

    // R5 sleep on system clock aborts, no resume; R9 config kept
    pulseStart(10'h0F0);
    repeat (5) tick();
    sleepIn = 1'b1;
    tick();
    check("R5 abort", int'(converting), 0);
    quietFor("R5 quiet in sleep", 20);
    sleepIn = 1'b0;
    quietFor("R5 no resume", 25);
    check("R9 cfgOn kept", int'(cfgOn), 1);
    pulseStart(10'h0F1);
    check("R9 start after sleep", int'(converting), 1);
    waitWrite("R9", 10'h0F1, n);
    check("R9 latency", n, LAT);
    check("R9 irq kept", int'(sawIrq), 1);
    tick();

    // R6 / R7 RC clock through sleep, interrupt off
    cfgWrite(1, 1, 0, 0, 3'b000);
    pulseStart(10'h3C3);
    sleepIn = 1'b1;
    waitWrite("R6", 10'h3C3, n);
    check("R6 latency in sleep", n, LAT);
    tick();
    check("R7 powered off", int'(modPowered), 0);
    check("R7 enable kept", int'(cfgOn), 1);
    sleepIn = 1'b0;
    pulseStart(10'h001);
    check("R7 start ignored", int'(converting), 0);

    // R6 with interrupt on: wakes, stays powered
    cfgWrite(1, 1, 0, 1, 3'b000);
    pulseStart(10'h1E1);
    sleepIn = 1'b1;
    waitWrite("R6", 10'h1E1, n);
    check("R6 wake irq", int'(sawIrq), 1);
    tick();
    check("R6 stays powered", int'(modPowered), 1);
    sleepIn = 1'b0;

    // R8 idle behaviour
    cfgWrite(1, 0, 0, 1, 3'b000);
    idleIn = 1'b1;
    pulseStart(10'h077);
    waitWrite("R8", 10'h077, n);
    check("R8 runs in idle", n, LAT);
    tick();
    idleIn = 1'b0;
    cfgWrite(1, 0, 1, 1, 3'b000);
    pulseStart(10'h078);
    repeat (4) tick();
    idleIn = 1'b1;
    tick();
    check("R8 abort in idle", int'(converting), 0);
    quietFor("R8 quiet in idle", 20);
    idleIn = 1'b0;
    quietFor("R8 no resume", 20);

    // R4 automatic trigger
    anaIn = 10'h2D2;
    cfgWrite(1, 0, 0, 0, 3'b111);
    waitWrite("R4", 10'h2D2, n);
    check("R4 first commit", n, LAT + 1);
    waitWrite("R4", 10'h2D2, n);
    check("R4 period", n, AUTO_PD);
    cfgWrite(0, 0, 0, 0, 3'b111);
    quietFor("R4 stops when off", 25);

    // R10 reset mid-conversion
    cfgWrite(1, 0, 0, 1, 3'b000);
    pulseStart(10'h123);
    repeat (6) tick();
    rst_n = 1'b0;
    #1;
    check("R10 converting", int'(converting), 0);
    check("R10 powered", int'(modPowered), 0);
    check("R10 cfgOn", int'(cfgOn), 0);
    check("R10 wrIdx", int'(wrIdx), 0);
    bIdx = 0;
    tick();
    rst_n = 1'b1;
    tick();
    pulseStart(10'h124);
    check("R10 config cleared", int'(converting), 0);

    // R2 / R3 constrained random: manual codes 0..6, random data and gaps
    for (int i = 0; i < 24; i++) begin
      logic irqR;
      logic [2:0] trg;
      logic [RES_W-1:0] code;
      irqR = 1'($urandom % 2);
      trg  = 3'($urandom % 7);
      code = RES_W'($urandom);
      cfgWrite(1, 1'($urandom % 2), 1'($urandom % 2), irqR, trg);
      repeat ($urandom % 4) tick();
      pulseStart(code);
      waitWrite("R2 random", code, n);
      check("R2 random latency", n, LAT);
      check("R3 random irq", int'(sawIrq), int'(irqR));
      tick();
    end

    summary();
  end

endmodule